// File: doc/BRIEF.md
# Dual Banked Stack Pointer Unit

This block keeps two independent stack contexts, one for ordinary program code and one for privileged or interrupt code. Each context is a 16-bit pointer plus an 8-bit bank byte. A single mode bit chooses the live context. Accepting an interrupt forces that bit to the privileged side, so every register save made during interrupt entry lands in the privileged stack.

A word push or pop request becomes two byte cycles on a byte-wide memory port. The 24-bit address is the bank byte followed by the 16-bit pointer. Pushes move the pointer down by two before storing. Pops fetch and then move the pointer up by two. Words are laid out low byte first. Software loads pointers and banks through a direct write port, and it reads them back on dedicated outputs.

Top module: `stkptr_unit`

## Requirements
- R1: With mode_o at 0 every push and pop uses the user pointer and user bank. With mode_o at 1 they use the system pointer and system bank.
- R2: A high irq_ack sets mode_o to 1 on the next edge. A push or pop accepted in the same cycle as irq_ack already uses the system pair.
- R3: Every memory address is the active bank byte in bits 23:16 and a 16-bit pointer-derived offset in bits 15:0.
- R4: A push first lowers the active pointer by 2. Its first byte cycle then addresses the new pointer value, and the pointer readback shows the new value.
- R5: A word is stored little-endian. Bits 7:0 go at the lower offset in the first byte cycle, and bits 15:8 go at offset plus 1 in the second byte cycle.
- R6: A pop reads the low byte at the current pointer and the high byte at pointer plus 1. It presents the joined word on pop_data while done is high, and it raises the active pointer by 2.
- R7: Pointer arithmetic and the byte-offset step wrap modulo 2^16. The bank byte never changes as a result.
- R8: A stack transfer leaves the inactive pointer and the inactive bank unchanged.
- R9: The two byte cycles (mem_en high, busy high) are the two cycles after acceptance. done is high for exactly the one cycle after the second byte cycle.
- R10: push_req and pop_req are ignored while busy is high. When both are high on an idle cycle, the push is taken.
- R11: sw_wr_sel chooses the register a software write updates: 0 user pointer, 1 system pointer, 2 user bank (low 8 bits of data), 3 system bank. The write is visible on the next cycle, and odd pointer values are kept as written. A write is dropped while busy is high or in a cycle that accepts a request.
- R12: After reset mode_o is 1, and busy, done and mem_en are 0. Pointers and banks are not initialised.
- R13: mode_wr_en loads mode_wr_val into mode_o on the next edge. irq_ack wins over it in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_ack | input | 1 | Interrupt accepted strobe; forces system mode |
| mode_wr_en | input | 1 | Software mode write enable |
| mode_wr_val | input | 1 | Mode value to write |
| push_req | input | 1 | Start a word push |
| push_data | input | 16 | Word to push |
| pop_req | input | 1 | Start a word pop |
| pop_data | output | 16 | Popped word, valid with done |
| done | output | 1 | One-cycle completion pulse |
| busy | output | 1 | Byte cycles in progress |
| sw_wr_en | input | 1 | Software register write enable |
| sw_wr_sel | input | 2 | Register select for software write |
| sw_wr_data | input | 16 | Software write data |
| usp_o | output | 16 | User pointer readback |
| ssp_o | output | 16 | System pointer readback |
| ubank_o | output | 8 | User bank readback |
| sbank_o | output | 8 | System bank readback |
| mode_o | output | 1 | Current mode bit (1 = system) |
| mem_en | output | 1 | Memory byte cycle strobe |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_addr | output | 24 | Memory byte address |
| mem_wdata | output | 8 | Memory write byte |
| mem_rdata | input | 8 | Memory read byte |

## Verification
Interrupt acceptance and the start of a stack transfer can occur in the same cycle. The bench raises irq_ack together with push_req while mode_o is 0. It then checks that the first byte cycle addresses the system bank and the lowered system pointer, that the user pair is unchanged, and that mode_o reads 1 afterwards. Software register writes and mode writes are also made to coincide with request acceptance and with irq_ack. The results are judged through the readback ports after the transfer completes.

// File: rtl/stkptr_pkg.sv
package stkptr_pkg;

    localparam int BYTE_W = 8;
    localparam int WORD_W = 2 * BYTE_W;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LO   = 2'd1,
        ST_HI   = 2'd2
    } xfer_st_e;

    typedef enum logic [1:0] {
        WSEL_UPTR  = 2'd0,
        WSEL_SPTR  = 2'd1,
        WSEL_UBANK = 2'd2,
        WSEL_SBANK = 2'd3
    } wsel_e;

endpackage

// File: rtl/stkptr_regs.sv
module stkptr_regs
    import stkptr_pkg::*;
#(
    parameter int PTR_W  = 16,
    parameter int BANK_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              irq_ack,
    input  logic              mode_wr_en,
    input  logic              mode_wr_val,
    input  logic              sw_wr_en,
    input  logic [1:0]        sw_wr_sel,
    input  logic [PTR_W-1:0]  sw_wr_data,
    input  logic              upd_en,
    input  logic              upd_sys,
    input  logic [PTR_W-1:0]  upd_ptr,
    output logic [PTR_W-1:0]  usp,
    output logic [PTR_W-1:0]  ssp,
    output logic [BANK_W-1:0] ubank,
    output logic [BANK_W-1:0] sbank,
    output logic              mode
);

    typedef struct packed {
        logic              mode;
        logic [PTR_W-1:0]  usp;
        logic [PTR_W-1:0]  ssp;
        logic [BANK_W-1:0] ubank;
        logic [BANK_W-1:0] sbank;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (irq_ack) begin
            r_d.mode = 1'b1;
        end else if (mode_wr_en) begin
            r_d.mode = mode_wr_val;
        end
        if (sw_wr_en) begin
            case (wsel_e'(sw_wr_sel))
                WSEL_UPTR:  r_d.usp   = sw_wr_data;
                WSEL_SPTR:  r_d.ssp   = sw_wr_data;
                WSEL_UBANK: r_d.ubank = sw_wr_data[BANK_W-1:0];
                WSEL_SBANK: r_d.sbank = sw_wr_data[BANK_W-1:0];
                default:    r_d = r_q;
            endcase
        end
        if (upd_en) begin
            if (upd_sys) begin
                r_d.ssp = upd_ptr;
            end else begin
                r_d.usp = upd_ptr;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.mode <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign usp   = r_q.usp;
    assign ssp   = r_q.ssp;
    assign ubank = r_q.ubank;
    assign sbank = r_q.sbank;
    assign mode  = r_q.mode;

    // R2
    irq_forces_sys_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |=> mode);

    // R11
    sw_vs_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upd_en |-> !sw_wr_en);

endmodule

// File: rtl/stkptr_seq.sv
module stkptr_seq
    import stkptr_pkg::*;
#(
    parameter int PTR_W  = 16,
    parameter int BANK_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     push_req,
    input  logic                     pop_req,
    input  logic [WORD_W-1:0]        push_data,
    input  logic                     eff_sys,
    input  logic [PTR_W-1:0]         act_ptr,
    input  logic [BANK_W-1:0]        act_bank,
    input  logic [BYTE_W-1:0]        mem_rdata,
    output logic                     accept,
    output logic                     busy,
    output logic                     upd_en,
    output logic                     upd_sys,
    output logic [PTR_W-1:0]         upd_ptr,
    output logic                     mem_en,
    output logic                     mem_we,
    output logic [BANK_W+PTR_W-1:0]  mem_addr,
    output logic [BYTE_W-1:0]        mem_wdata,
    output logic                     done,
    output logic [WORD_W-1:0]        pop_data
);

    localparam logic [PTR_W-1:0] STEP = PTR_W'(2);
    localparam logic [PTR_W-1:0] ONE  = PTR_W'(1);

    typedef struct packed {
        xfer_st_e           st;
        logic               sys;
        logic               is_push;
        logic [BANK_W-1:0]  bank;
        logic [PTR_W-1:0]   base;
        logic [WORD_W-1:0]  wdata;
        logic [BYTE_W-1:0]  rlo;
        logic [WORD_W-1:0]  pop_data;
        logic               done;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        s_d.done = 1'b0;
        upd_en  = 1'b0;
        upd_sys = s_q.sys;
        upd_ptr = s_q.base;
        accept  = 1'b0;
        case (s_q.st)
            ST_IDLE: begin
                if (push_req || pop_req) begin
                    accept    = 1'b1;
                    s_d.st    = ST_LO;
                    s_d.sys   = eff_sys;
                    s_d.bank  = act_bank;
                    s_d.wdata = push_data;
                    if (push_req) begin
                        s_d.is_push = 1'b1;
                        s_d.base    = act_ptr - STEP;
                        upd_en      = 1'b1;
                        upd_sys     = eff_sys;
                        upd_ptr     = act_ptr - STEP;
                    end else begin
                        s_d.is_push = 1'b0;
                        s_d.base    = act_ptr;
                    end
                end
            end
            ST_LO: begin
                if (!s_q.is_push) begin
                    s_d.rlo = mem_rdata;
                end
                s_d.st = ST_HI;
            end
            ST_HI: begin
                s_d.st   = ST_IDLE;
                s_d.done = 1'b1;
                if (!s_q.is_push) begin
                    s_d.pop_data = {mem_rdata, s_q.rlo};
                    upd_en       = 1'b1;
                    upd_sys      = s_q.sys;
                    upd_ptr      = s_q.base + STEP;
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy      = (s_q.st != ST_IDLE);
    assign mem_en    = busy;
    assign mem_we    = busy && s_q.is_push;
    assign mem_addr  = {s_q.bank, (s_q.st == ST_HI) ? (s_q.base + ONE) : s_q.base};
    assign mem_wdata = (s_q.st == ST_HI) ? s_q.wdata[WORD_W-1:BYTE_W] : s_q.wdata[BYTE_W-1:0];
    assign done      = s_q.done;
    assign pop_data  = s_q.pop_data;

    // R9
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R5
    hi_byte_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == ST_HI) |-> (mem_addr[PTR_W-1:0] == PTR_W'($past(mem_addr[PTR_W-1:0]) + ONE))
                              && $stable(mem_addr[BANK_W+PTR_W-1:PTR_W]));

    // R3
    first_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> mem_en && (mem_addr == {$past(act_bank),
            ($past(push_req) ? PTR_W'($past(act_ptr) - STEP) : $past(act_ptr))}));

    // R10
    busy_no_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !accept);

endmodule

// File: rtl/stkptr_unit.sv
module stkptr_unit
    import stkptr_pkg::*;
#(
    parameter int PTR_W  = 16,
    parameter int BANK_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     irq_ack,
    input  logic                     mode_wr_en,
    input  logic                     mode_wr_val,
    input  logic                     push_req,
    input  logic [15:0]              push_data,
    input  logic                     pop_req,
    output logic [15:0]              pop_data,
    output logic                     done,
    output logic                     busy,
    input  logic                     sw_wr_en,
    input  logic [1:0]               sw_wr_sel,
    input  logic [PTR_W-1:0]         sw_wr_data,
    output logic [PTR_W-1:0]         usp_o,
    output logic [PTR_W-1:0]         ssp_o,
    output logic [BANK_W-1:0]        ubank_o,
    output logic [BANK_W-1:0]        sbank_o,
    output logic                     mode_o,
    output logic                     mem_en,
    output logic                     mem_we,
    output logic [BANK_W+PTR_W-1:0]  mem_addr,
    output logic [7:0]               mem_wdata,
    input  logic [7:0]               mem_rdata
);

    logic              accept;
    logic              eff_sys;
    logic              sw_go;
    logic              push_go;
    logic              upd_en;
    logic              upd_sys;
    logic [PTR_W-1:0]  upd_ptr;
    logic [PTR_W-1:0]  act_ptr;
    logic [BANK_W-1:0] act_bank;

    assign eff_sys  = irq_ack | mode_o;
    assign act_ptr  = eff_sys ? ssp_o : usp_o;
    assign act_bank = eff_sys ? sbank_o : ubank_o;
    assign sw_go    = sw_wr_en && !busy && !accept;
    assign push_go  = accept && push_req;

    stkptr_regs #(
        .PTR_W  (PTR_W),
        .BANK_W (BANK_W)
    ) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .irq_ack     (irq_ack),
        .mode_wr_en  (mode_wr_en),
        .mode_wr_val (mode_wr_val),
        .sw_wr_en    (sw_go),
        .sw_wr_sel   (sw_wr_sel),
        .sw_wr_data  (sw_wr_data),
        .upd_en      (upd_en),
        .upd_sys     (upd_sys),
        .upd_ptr     (upd_ptr),
        .usp         (usp_o),
        .ssp         (ssp_o),
        .ubank       (ubank_o),
        .sbank       (sbank_o),
        .mode        (mode_o)
    );

    stkptr_seq #(
        .PTR_W  (PTR_W),
        .BANK_W (BANK_W)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_req  (push_req),
        .pop_req   (pop_req),
        .push_data (push_data),
        .eff_sys   (eff_sys),
        .act_ptr   (act_ptr),
        .act_bank  (act_bank),
        .mem_rdata (mem_rdata),
        .accept    (accept),
        .busy      (busy),
        .upd_en    (upd_en),
        .upd_sys   (upd_sys),
        .upd_ptr   (upd_ptr),
        .mem_en    (mem_en),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .done      (done),
        .pop_data  (pop_data)
    );

    // R4
    push_predec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push_go |=> (($past(eff_sys) ? ssp_o : usp_o) == PTR_W'($past(act_ptr) - PTR_W'(2))));

    // R8
    user_push_keeps_sys_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push_go && !eff_sys) |=> ($stable(ssp_o) && $stable(sbank_o)));

    // R8
    sys_push_keeps_user_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push_go && eff_sys) |=> ($stable(usp_o) && $stable(ubank_o)));

endmodule

// File: tb/stkptr_unit_tb.sv
`timescale 1ns/1ps
module stkptr_unit_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        irq_ack = 1'b0;
    logic        mode_wr_en = 1'b0;
    logic        mode_wr_val = 1'b0;
    logic        push_req = 1'b0;
    logic [15:0] push_data = '0;
    logic        pop_req = 1'b0;
    logic [15:0] pop_data;
    logic        done;
    logic        busy;
    logic        sw_wr_en = 1'b0;
    logic [1:0]  sw_wr_sel = '0;
    logic [15:0] sw_wr_data = '0;
    logic [15:0] usp_o, ssp_o;
    logic [7:0]  ubank_o, sbank_o;
    logic        mode_o;
    logic        mem_en, mem_we;
    logic [23:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata = '0;

    int checks = 0;
    int errors = 0;

    logic [15:0] e_usp, e_ssp;
    logic [7:0]  e_ub, e_sb;
    logic        e_mode;

    logic [7:0] mem [logic [23:0]];

    always #2.5 clk = ~clk;

    stkptr_unit u_dut (
        .clk(clk), .rst_n(rst_n), .irq_ack(irq_ack),
        .mode_wr_en(mode_wr_en), .mode_wr_val(mode_wr_val),
        .push_req(push_req), .push_data(push_data), .pop_req(pop_req),
        .pop_data(pop_data), .done(done), .busy(busy),
        .sw_wr_en(sw_wr_en), .sw_wr_sel(sw_wr_sel), .sw_wr_data(sw_wr_data),
        .usp_o(usp_o), .ssp_o(ssp_o), .ubank_o(ubank_o), .sbank_o(sbank_o),
        .mode_o(mode_o), .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    always @(negedge clk) begin
        if (mem_en && mem_we) mem[mem_addr] = mem_wdata;
        mem_rdata <= mem.exists(mem_addr) ? mem[mem_addr] : 8'h00;
    end

    task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic chk_regs(input string tag);
        chk(usp_o == e_usp, tag, usp_o, e_usp);
        chk(ssp_o == e_ssp, tag, ssp_o, e_ssp);
        chk(ubank_o == e_ub, tag, ubank_o, e_ub);
        chk(sbank_o == e_sb, tag, sbank_o, e_sb);
        chk(mode_o == e_mode, tag, mode_o, e_mode);
    endtask

    task automatic sw_wr(input logic [1:0] sel, input logic [15:0] val);
        sw_wr_en = 1'b1; sw_wr_sel = sel; sw_wr_data = val;
        @(negedge clk);
        sw_wr_en = 1'b0;
        case (sel)
            2'd0: e_usp = val;
            2'd1: e_ssp = val;
            2'd2: e_ub  = val[7:0];
            default: e_sb = val[7:0];
        endcase
    endtask

    task automatic set_mode(input logic m);
        mode_wr_en = 1'b1; mode_wr_val = m;
        @(negedge clk);
        mode_wr_en = 1'b0;
        e_mode = m;
    endtask

    task automatic do_push(input logic [15:0] d);
        logic [15:0] p, np;
        logic [7:0]  b;
        p  = e_mode ? e_ssp : e_usp;
        b  = e_mode ? e_sb : e_ub;
        np = p - 16'd2;
        push_req = 1'b1; push_data = d;
        @(negedge clk);
        push_req = 1'b0;
        chk(mem_en && mem_we && busy, "R9 push lo cycle", {mem_en, mem_we, busy}, 3'b111);
        chk(mem_addr == {b, np}, "R4 push lo addr", mem_addr, {b, np});
        chk(mem_wdata == d[7:0], "R5 push lo byte", mem_wdata, d[7:0]);
        @(negedge clk);
        chk(mem_addr == {b, np + 16'd1}, (np == 16'hFFFF) ? "R7 push hi wrap" : "R5 push hi addr",
            mem_addr, {b, np + 16'd1});
        chk(mem_wdata == d[15:8], "R5 push hi byte", mem_wdata, d[15:8]);
        chk(!done, "R9 no early done", done, 0);
        @(negedge clk);
        chk(done && !busy && !mem_en, "R9 push done", {done, busy, mem_en}, 3'b100);
        if (e_mode) e_ssp = np; else e_usp = np;
        chk_regs((np > p) ? "R7 R8 push regs" : "R8 push regs");
    endtask

    task automatic do_pop(input logic [15:0] expd);
        logic [15:0] p;
        logic [7:0]  b;
        p = e_mode ? e_ssp : e_usp;
        b = e_mode ? e_sb : e_ub;
        pop_req = 1'b1;
        @(negedge clk);
        pop_req = 1'b0;
        chk(mem_en && !mem_we, "R6 pop lo read", {mem_en, mem_we}, 2'b10);
        chk(mem_addr == {b, p}, "R6 pop lo addr", mem_addr, {b, p});
        @(negedge clk);
        chk(mem_addr == {b, p + 16'd1}, "R6 pop hi addr", mem_addr, {b, p + 16'd1});
        @(negedge clk);
        chk(done, "R9 pop done", done, 1);
        chk(pop_data == expd, "R6 pop data", pop_data, expd);
        if (e_mode) e_ssp = p + 16'd2; else e_usp = p + 16'd2;
        chk_regs("R1 R8 pop regs");
    endtask

    function automatic logic [15:0] ptr_pick(input int i);
        case (i)
            0: return 16'hF328;
            1: return 16'h0000;
            2: return 16'h0001;
            3: return 16'hFFFF;
            4: return 16'h8001;
            default: return 16'h1234;
        endcase
    endfunction

    initial begin
        #(200000 * 5);
        checks++; errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(mode_o == 1'b1, "R12 reset mode", mode_o, 1);
        chk(!busy && !done && !mem_en, "R12 reset idle", {busy, done, mem_en}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        e_mode = 1'b1;

        sw_wr(2'd0, 16'h1235);
        sw_wr(2'd1, 16'h0F00);
        sw_wr(2'd2, 16'h00C6);
        sw_wr(2'd3, 16'hAB56);
        chk_regs("R11 sw load odd");
        set_mode(1'b0);
        chk(mode_o == 1'b0, "R13 mode write", mode_o, 0);

        for (int m = 0; m < 2; m++) begin
            set_mode(m[0]);
            for (int i = 0; i < 6; i++) begin
                logic [15:0] d;
                d = 16'hA624 ^ 16'(i * 16'h1111) ^ 16'(m * 16'h0F0F);
                sw_wr(m[0] ? 2'd1 : 2'd0, ptr_pick(i));
                do_push(d);
                do_push(~d);
                do_pop(~d);
                do_pop(d);
                chk((m[0] ? ssp_o : usp_o) == ptr_pick(i), "R1 R7 ptr restored",
                    m[0] ? ssp_o : usp_o, ptr_pick(i));
            end
        end

        set_mode(1'b0);
        sw_wr(2'd0, 16'hF328);
        push_req = 1'b1; push_data = 16'h1357;
        @(negedge clk);
        push_req = 1'b0;
        pop_req = 1'b1; sw_wr_en = 1'b1; sw_wr_sel = 2'd0; sw_wr_data = 16'h4444;
        @(negedge clk);
        pop_req = 1'b0; sw_wr_en = 1'b0;
        @(negedge clk);
        chk(done, "R10 busy push done", done, 1);
        e_usp = 16'hF326;
        chk_regs("R10 R11 ignored while busy");
        @(negedge clk);
        chk(!mem_en && !busy, "R10 no queued transfer", {mem_en, busy}, 0);

        push_req = 1'b1; pop_req = 1'b1; push_data = 16'h2468;
        @(negedge clk);
        push_req = 1'b0; pop_req = 1'b0;
        chk(mem_we, "R10 push priority", mem_we, 1);
        chk(mem_addr == {8'hC6, 16'hF324}, "R10 push priority addr", mem_addr, {8'hC6, 16'hF324});
        repeat (2) @(negedge clk);
        e_usp = 16'hF324;
        chk_regs("R10 after both");

        sw_wr_en = 1'b1; sw_wr_sel = 2'd0; sw_wr_data = 16'h7777; push_req = 1'b1; push_data = 16'h0101;
        @(negedge clk);
        sw_wr_en = 1'b0; push_req = 1'b0;
        repeat (2) @(negedge clk);
        e_usp = 16'hF322;
        chk_regs("R11 write dropped on accept");

        sw_wr(2'd1, 16'h1234);
        irq_ack = 1'b1; push_req = 1'b1; push_data = 16'hA624;
        @(negedge clk);
        irq_ack = 1'b0; push_req = 1'b0;
        chk(mem_addr == {8'h56, 16'h1232}, "R2 irq same-cycle addr", mem_addr, {8'h56, 16'h1232});
        chk(mem_wdata == 8'h24, "R2 R5 irq lo byte", mem_wdata, 8'h24);
        chk(mode_o == 1'b1, "R2 mode forced", mode_o, 1);
        @(negedge clk);
        chk(mem_wdata == 8'hA6, "R5 irq hi byte", mem_wdata, 8'hA6);
        @(negedge clk);
        e_ssp = 16'h1232; e_mode = 1'b1;
        chk_regs("R2 R8 irq push regs");
        chk(mem[{8'h56, 16'h1232}] == 8'h24 && mem[{8'h56, 16'h1233}] == 8'hA6, "R3 R5 memory image",
            {mem[{8'h56, 16'h1233}], mem[{8'h56, 16'h1232}]}, 16'hA624);

        set_mode(1'b0);
        irq_ack = 1'b1; mode_wr_en = 1'b1; mode_wr_val = 1'b0;
        @(negedge clk);
        irq_ack = 1'b0; mode_wr_en = 1'b0;
        chk(mode_o == 1'b1, "R13 irq beats mode write", mode_o, 1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule